// File: doc/BRIEF.md
# Lockstep Retirement Comparator with Runaway Guard

This block watches two retirement streams running side by side: one from a processor core under test and one from a reference model. Each cycle, either stream may present one retired instruction: its program counter and an optional write to an architectural register. The block pairs retirements in order and checks that both streams reach the same register state. It also watches for execution that can no longer make progress, and for runs that exceed a fixed retirement budget. The first of these verdicts ends the run. The verdict is latched and `halt` is raised.

Each side has a four-entry queue, so the two streams may drift apart by a few retirements. Register state is compared only when a retirement actually alters a register. A shadow register file, shared by both sides, tells real changes apart from rewrites of the same value. A 16-entry table records program counters seen since the last state change. A pulse on `start` clears the verdict, the queues, the table, the shadow registers and the budget counter, and begins a new run.

Top module: `lockstep_checker`

## Requirements
- R1: After reset or a `start` pulse, `status` is 0 (running, no failure) and `halt` is low.
- R2: When the program counters of a paired retirement differ, `status` becomes 2 and `halt` rises.
- R3: A paired retirement in which either side changes a register value is a synchronization point. There, unless both sides changed the same register to the same value, `status` becomes 1 and `halt` rises.
- R4: Writes to register 0, and writes that store the value the register already holds, are not changes. Such a write on one side alone causes no error.
- R5: A paired retirement with no register change, whose program counter is already in the visited table, sets `status` to 3 (loop stop) and raises `halt`.
- R6: Any register change empties the visited table, and the changing retirement's program counter is not recorded. A program counter that recurs across a change is therefore not a loop.
- R7: The visited table holds 16 program counters. Further program counters are dropped while it is full, so a recurrence of a dropped one is not detected, but a recurrence of a stored one still is.
- R8: On the clock edge that accepts the 10,000th reference retirement, `status` becomes 4 (budget stop) and `halt` rises, unless an earlier verdict is already latched.
- R9: When verdicts arise on the same edge, a mismatch (2 before 1) wins over loop stop (3), and loop stop wins over budget stop (4).
- R10: Retirements are paired in order. The reference side may lead by up to 4 retirements, and a pair is compared only once both sides hold it.
- R11: While `halt` is high, commit inputs are ignored and `status` holds its value until `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Synchronous clear that begins a new run |
| dut_valid | input | 1 | Core under test retires an instruction |
| dut_pc | input | 32 | Retired program counter, core under test |
| dut_wen | input | 1 | Retirement writes a register, core under test |
| dut_rd | input | 5 | Destination register index, core under test |
| dut_wdata | input | 32 | Written value, core under test |
| ref_valid | input | 1 | Reference model retires an instruction |
| ref_pc | input | 32 | Retired program counter, reference |
| ref_wen | input | 1 | Retirement writes a register, reference |
| ref_rd | input | 5 | Destination register index, reference |
| ref_wdata | input | 32 | Written value, reference |
| status | output | 3 | 0 running, 1 register mismatch, 2 PC mismatch, 3 loop stop, 4 budget stop |
| halt | output | 1 | Run has ended; stays high until start |

## Verification
A corrupted shadow register shows up at the ports as a false register mismatch, or as a missed one. This happens at the first paired write to that register, one edge after both halves of the pair have been queued. A visited table that is stale or flushed at the wrong time shows up as a loop stop that fires too early or never fires. The directed sequences make this visible within a few retirements. A misaligned queue pointer pairs the wrong retirements and gives a PC mismatch on the next pair. A wrong budget counter moves the edge at which status 4 appears, or lets it override a mismatch that arrives on the same edge.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  localparam int XLEN = 32;
  localparam int RIDX = 5;

  typedef struct packed {
    logic [XLEN-1:0] pc;
    logic            wen;
    logic [RIDX-1:0] rd;
    logic [XLEN-1:0] data;
  } commit_t;

  typedef enum logic [2:0] {
    V_RUN    = 3'd0,
    V_REGERR = 3'd1,
    V_PCERR  = 3'd2,
    V_LOOP   = 3'd3,
    V_BUDGET = 3'd4
  } verdict_e;

  // A write counts as a state change only if it targets a real register
  // and stores a value different from the one already held.
  function automatic logic alters_state(input logic wen, input logic [RIDX-1:0] rd,
                                        input logic [XLEN-1:0] nv,
                                        input logic [XLEN-1:0] ov);
    return wen && (rd != '0) && (nv != ov);
  endfunction

  // Earliest-listed event wins.
  function automatic verdict_e pick_verdict(input logic pc_e, input logic reg_e,
                                            input logic loop_e, input logic bud_e);
    if (pc_e)   return V_PCERR;
    if (reg_e)  return V_REGERR;
    if (loop_e) return V_LOOP;
    if (bud_e)  return V_BUDGET;
    return V_RUN;
  endfunction
endpackage

// File: rtl/lsc_fifo.sv
module lsc_fifo #(
  parameter int W     = 70,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign empty   = (cnt == '0);
  assign do_push = push && (cnt != CW'(DEPTH));
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else if (clr) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  // R10
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  // R10
  fifo_pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_pop && !clr && !do_push) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/lsc_shadow_rf.sv
module lsc_shadow_rf #(
  parameter int NREGS = 32,
  parameter int XW    = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic [$clog2(NREGS)-1:0] ra_a,
  output logic [XW-1:0]            rv_a,
  input  logic [$clog2(NREGS)-1:0] ra_b,
  output logic [XW-1:0]            rv_b,
  input  logic                     we,
  input  logic [$clog2(NREGS)-1:0] wa,
  input  logic [XW-1:0]            wv
);
  logic [XW-1:0] regs [NREGS];

  assign rv_a = regs[ra_a];
  assign rv_b = regs[ra_b];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (clr) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (we && wa != '0) begin
      regs[wa] <= wv;
    end
  end

  // R4
  zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    regs[0] == '0);
endmodule

// File: rtl/lsc_pc_table.sv
module lsc_pc_table #(
  parameter int DEPTH = 16,
  parameter int AW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [AW-1:0] look_pc,
  output logic          hit,
  input  logic          ins,
  input  logic          flush
);
  localparam int FW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [AW-1:0] pcs [DEPTH];
  logic [FW-1:0] fill;
  logic [DEPTH-1:0] match;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign match[i] = (FW'(i) < fill) && (pcs[i] == look_pc);
  end
  assign hit = |match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill <= '0;
    end else if (clr || flush) begin
      fill <= '0;
    end else if (ins && fill != FW'(DEPTH)) begin
      fill <= fill + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!clr && !flush && ins && fill != FW'(DEPTH)) pcs[fill[IW-1:0]] <= look_pc;
  end

  // R6
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (fill == '0));
  // R7
  fill_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FW'(DEPTH));
  // R5
  hit_needs_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (fill != '0));
endmodule

// File: rtl/lockstep_checker.sv
module lockstep_checker
  import lsc_pkg::*;
#(
  parameter int BUDGET     = 10000,
  parameter int QDEPTH     = 4,
  parameter int TBL_DEPTH  = 16,
  parameter int NREGS      = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            dut_valid,
  input  logic [XLEN-1:0] dut_pc,
  input  logic            dut_wen,
  input  logic [RIDX-1:0] dut_rd,
  input  logic [XLEN-1:0] dut_wdata,
  input  logic            ref_valid,
  input  logic [XLEN-1:0] ref_pc,
  input  logic            ref_wen,
  input  logic [RIDX-1:0] ref_rd,
  input  logic [XLEN-1:0] ref_wdata,
  output logic [2:0]      status,
  output logic            halt
);
  localparam int CW = $clog2(BUDGET + 1);
  localparam int EW = $bits(commit_t);

  commit_t  d_in, r_in, d_hd, r_hd;
  logic     d_empty, r_empty;
  logic     pair, d_chg, r_chg, sync;
  logic     pc_evt, reg_evt, loop_evt, bud_evt, tbl_hit;
  logic     ref_acc;
  logic [XLEN-1:0] d_old, r_old;
  logic [CW-1:0]   ref_cnt;
  verdict_e verdict_q, verdict_d;

  assign d_in = '{pc: dut_pc, wen: dut_wen, rd: dut_rd, data: dut_wdata};
  assign r_in = '{pc: ref_pc, wen: ref_wen, rd: ref_rd, data: ref_wdata};

  logic [EW-1:0] d_hd_raw, r_hd_raw;
  assign d_hd = commit_t'(d_hd_raw);
  assign r_hd = commit_t'(r_hd_raw);

  lsc_fifo #(.W(EW), .DEPTH(QDEPTH)) u_dq (
    .clk, .rst_n, .clr(start), .push(dut_valid && !halt && !start), .din(d_in),
    .pop(pair), .dout(d_hd_raw), .empty(d_empty));
  lsc_fifo #(.W(EW), .DEPTH(QDEPTH)) u_rq (
    .clk, .rst_n, .clr(start), .push(ref_acc), .din(r_in),
    .pop(pair), .dout(r_hd_raw), .empty(r_empty));

  assign pair    = !d_empty && !r_empty && !halt && !start;
  assign ref_acc = ref_valid && !halt && !start;

  lsc_shadow_rf #(.NREGS(NREGS), .XW(XLEN)) u_rf (
    .clk, .rst_n, .clr(start),
    .ra_a(d_hd.rd), .rv_a(d_old), .ra_b(r_hd.rd), .rv_b(r_old),
    .we(pair && r_chg && !pc_evt && !reg_evt), .wa(r_hd.rd), .wv(r_hd.data));

  assign d_chg = alters_state(d_hd.wen, d_hd.rd, d_hd.data, d_old);
  assign r_chg = alters_state(r_hd.wen, r_hd.rd, r_hd.data, r_old);
  assign sync  = d_chg || r_chg;

  assign pc_evt  = pair && (d_hd.pc != r_hd.pc);
  assign reg_evt = pair && sync &&
                   !(d_chg && r_chg && d_hd.rd == r_hd.rd && d_hd.data == r_hd.data);

  lsc_pc_table #(.DEPTH(TBL_DEPTH), .AW(XLEN)) u_tbl (
    .clk, .rst_n, .clr(start), .look_pc(r_hd.pc), .hit(tbl_hit),
    .ins(pair && !sync && !tbl_hit), .flush(pair && sync));

  assign loop_evt = pair && !sync && tbl_hit;
  assign bud_evt  = ref_acc && (ref_cnt == CW'(BUDGET - 1));

  assign verdict_d = pick_verdict(pc_evt, reg_evt, loop_evt, bud_evt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      verdict_q <= V_RUN; halt <= 1'b0; ref_cnt <= '0;
    end else if (start) begin
      verdict_q <= V_RUN; halt <= 1'b0; ref_cnt <= '0;
    end else if (!halt) begin
      if (ref_acc) ref_cnt <= ref_cnt + 1'b1;
      if (verdict_d != V_RUN) begin
        verdict_q <= verdict_d;
        halt      <= 1'b1;
      end
    end
  end

  assign status = verdict_q;

  // R11
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !start) |=> (halt && $stable(status) && $stable(ref_cnt)));
  // R8
  budget_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_cnt <= CW'(BUDGET));
  // R2
  pc_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_evt && !start) |=> (halt && status == V_PCERR));
  // R1
  run_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!halt && status == V_RUN));
  // R1
  halt_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt == (status != V_RUN));
endmodule

// File: tb/lockstep_checker_test.sv
module lockstep_checker_test;
  logic clk = 0, rst_n = 0, start = 0;
  logic dv = 0, dw = 0, rv = 0, rw = 0;
  logic [31:0] dpc = 0, dd = 0, rpc = 0, rdv = 0;
  logic [4:0] drd = 0, rrd = 0;
  logic [2:0] status;
  logic halt;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  lockstep_checker uut (
    .clk, .rst_n, .start,
    .dut_valid(dv), .dut_pc(dpc), .dut_wen(dw), .dut_rd(drd), .dut_wdata(dd),
    .ref_valid(rv), .ref_pc(rpc), .ref_wen(rw), .ref_rd(rrd), .ref_wdata(rdv),
    .status, .halt);

  // Bench model of the expected verdict.
  logic [31:0] mregs [32];
  logic [31:0] mtab [16];
  int mfill;
  int mv;

  task automatic m_clear();
    for (int i = 0; i < 32; i++) mregs[i] = 0;
    mfill = 0; mv = 0;
  endtask

  function automatic logic real_change(logic w, logic [4:0] r, logic [31:0] v);
    return w && r != 0 && mregs[r] != v;
  endfunction

  task automatic m_pair(logic [31:0] ap, logic aw, logic [4:0] ar, logic [31:0] ad,
                        logic [31:0] bp, logic bw, logic [4:0] br, logic [31:0] bd);
    logic ca, cb, seen;
    if (mv != 0) return;
    ca = real_change(aw, ar, ad);
    cb = real_change(bw, br, bd);
    if (ap != bp) mv = 2;
    else if ((ca || cb) && !(ca && cb && ar == br && ad == bd)) mv = 1;
    else if (ca || cb) begin mregs[br] = bd; mfill = 0; end
    else begin
      seen = 0;
      for (int k = 0; k < mfill; k++) if (mtab[k] == bp) seen = 1;
      if (seen) mv = 3;
      else if (mfill < 16) begin mtab[mfill] = bp; mfill++; end
    end
  endtask

  task automatic check(string req, logic [2:0] exp_st);
    logic exp_h;
    exp_h = (exp_st != 0);
    checks++;
    if (status !== exp_st || halt !== exp_h) begin
      fails++;
      $display("FAIL %s: status=%0d halt=%0b expected status=%0d halt=%0b",
               req, status, halt, exp_st, exp_h);
    end
  endtask

  task automatic pair(logic [31:0] p, logic w, logic [4:0] r, logic [31:0] v,
                      logic [31:0] q, logic x, logic [4:0] s, logic [31:0] u);
    @(negedge clk);
    dv = 1; dpc = p; dw = w; drd = r; dd = v;
    rv = 1; rpc = q; rw = x; rrd = s; rdv = u;
    m_pair(p, w, r, v, q, x, s, u);
  endtask

  task automatic same(logic [31:0] p, logic w, logic [4:0] r, logic [31:0] v);
    pair(p, w, r, v, p, w, r, v);
  endtask

  task automatic settle();
    @(negedge clk); dv = 0; rv = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic restart();
    @(negedge clk); dv = 0; rv = 0; start = 1;
    @(negedge clk); start = 0;
    m_clear();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    m_clear();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset", 0);

    // R2 pc mismatch
    pair(32'h100, 0, 0, 0, 32'h104, 0, 0, 0); settle();
    check("R2 pc mismatch", 2);
    restart(); check("R1 start clears", 0);

    // R3 register value mismatch
    pair(32'h100, 1, 1, 5, 32'h100, 1, 1, 6); settle();
    check("R3 data mismatch", 1);
    restart();
    pair(32'h100, 1, 2, 5, 32'h100, 1, 1, 5); settle();
    check("R3 register index mismatch", 1);
    restart();

    // R4 writes to x0 and same-value writes are not changes
    pair(32'h200, 1, 0, 7, 32'h200, 0, 0, 0);
    pair(32'h204, 1, 3, 0, 32'h204, 0, 0, 0);
    same(32'h208, 1, 3, 9);
    pair(32'h20c, 1, 3, 9, 32'h20c, 0, 0, 0);
    settle(); check("R4 non-changing writes", 0);
    restart();

    // R5 loop
    same(32'h100, 0, 0, 0); same(32'h104, 0, 0, 0); same(32'h100, 0, 0, 0);
    settle(); check("R5 loop stop", 3);
    restart();

    // R6 change flushes table
    same(32'h100, 0, 0, 0); same(32'h104, 1, 1, 1); same(32'h100, 0, 0, 0);
    settle(); check("R6 recurrence across change", 0);
    same(32'h100, 0, 0, 0); settle();
    check("R6 recurrence after change", 3);
    restart();

    // R7 table capacity
    for (int i = 0; i < 17; i++) same(32'h400 + 4 * i, 0, 0, 0);
    same(32'h400 + 4 * 16, 0, 0, 0); settle();
    check("R7 dropped entry not detected", 0);
    same(32'h400, 0, 0, 0); settle();
    check("R7 stored entry detected", 3);
    restart();

    // R10 reference leads by 4
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); rv = 1; rpc = 32'h500 + 4 * i; rw = 1; rrd = 5'd4; rdv = i + 1;
    end
    @(negedge clk); rv = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); dv = 1; dpc = 32'h500 + 4 * i; dw = 1; drd = 5'd4; dd = i + 1;
    end
    settle(); check("R10 skewed matched", 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); rv = 1; rpc = 32'h600 + 4 * i; rw = 0; rrd = 0; rdv = 0;
    end
    @(negedge clk); rv = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); dv = 1; dw = 0; drd = 0; dd = 0;
      dpc = (i == 3) ? 32'h6f0 : 32'h600 + 4 * i;
    end
    settle(); check("R10 skewed fourth pair mismatch", 2);

    // R11 inputs ignored while halted
    m_clear(); mv = 2;
    pair(32'h700, 1, 1, 1, 32'h704, 1, 1, 2);
    same(32'h700, 0, 0, 0); same(32'h700, 0, 0, 0);
    settle(); check("R11 halted status held", 2);
    restart(); check("R11 start releases halt", 0);

    // R8 budget
    for (int i = 1; i <= 9999; i++) same(32'h1000 + 4 * (i % 8), 1, 1, i);
    settle(); check("R8 below budget", 0);
    same(32'h1000, 1, 1, 32'hffff); settle();
    check("R8 budget stop", 4);
    restart();

    // R9 mismatch beats budget on the same edge
    for (int i = 1; i <= 9998; i++) same(32'h1000 + 4 * (i % 8), 1, 1, i);
    pair(32'h1abc, 0, 0, 0, 32'h1000, 0, 0, 0);
    same(32'h1004, 0, 0, 0);
    settle(); check("R9 mismatch over budget", 2);
    restart();

    // R9 loop beats budget on the same edge
    for (int i = 1; i <= 9997; i++) same(32'h1000 + 4 * (i % 8), 1, 1, i);
    same(32'h2000, 0, 0, 0); same(32'h2000, 0, 0, 0); same(32'h2004, 0, 0, 0);
    settle(); check("R9 loop over budget", 3);
    restart();

    // Random streams, R2 R3 R4 R5 against the bench model
    for (int t = 0; t < 24; t++) begin
      for (int i = 0; i < 30; i++) begin
        logic [31:0] p, v, pe, ve;
        logic w;
        logic [4:0] r;
        p = 32'h300 + 4 * $urandom_range(0, 7);
        w = $urandom_range(0, 1);
        r = $urandom_range(0, 3);
        v = $urandom_range(0, 3);
        pe = p; ve = v;
        if ($urandom_range(0, 49) == 0) pe = p ^ 32'h10;
        if ($urandom_range(0, 29) == 0) ve = v + 1;
        pair(pe, w, r, ve, p, w, r, v);
      end
      settle();
      check("R2 R3 R4 R5 random stream", mv[2:0]);
      restart();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule